// File: doc/BRIEF.md
# Chip-select timing generator

This block produces the control waveforms for one synchronous burst access to a NOR-style memory. It runs on a fast functional clock. A start pulse with a read/write flag begins an access. At that start, the block captures the timing fields, all counted in functional-clock ticks: clock-start tick, chip-select assert tick, access tick, read end tick and write end tick. It also captures a divider select, a granularity bit, a half-tick delay bit and a read burst length.

From the captured fields the block generates the following outputs:
- a memory clock at the functional clock divided by 1, 2 or 3;
- an active-low chip-select;
- an address/byte-enable valid strobe;
- a read-data capture strobe.

The chip-select assert point is moved later by whole ticks, as a function of the divider, so that it holds a fixed relation to the memory-clock phase. It can also be retimed on the falling functional-clock edge to add half a tick. A done pulse closes each access. Starts that arrive during an access are dropped.

Top module: `cs_timing_gen`

## Requirements
- R1: The divider select gives N = 1, 2 or 3 for the codes 0, 1 and 2. Code 3 acts as 0. Memory-clock rising edges are N ticks apart. Each high phase lasts N half-ticks. The number of rising edges is the number of ticks t with clock-start ≤ t < end tick, where t minus clock-start is a multiple of N.
- R2: The address/byte-enable valid strobe rises at the start of the access. The first memory-clock rising edge comes exactly clock-start ticks later. The strobe falls end-tick ticks after it rose. The memory clock does not toggle after that point.
- R3: When N is 1, chip-select asserts at the assert tick. When N is 2, it asserts at the assert tick if the assert tick and the clock-start tick have equal parity, and one tick later otherwise.
- R4: When N is 3, chip-select asserts (assert tick − clock-start tick) mod 3 ticks after the assert tick. The mod is taken as a non-negative value, including when the assert tick comes before the clock-start tick.
- R5: With the half-tick delay bit set, the chip-select falling edge comes half a functional-clock period later than it otherwise would. The rising edge does not move.
- R6: Chip-select deasserts at the end tick. For reads the end tick is the read end field. For writes it is the write end field. This equals the access tick plus (end field − access field) × (granularity + 1).
- R7: With the granularity bit set, every timing field counts double.
- R8: A read produces exactly burst-length capture pulses. One pulse falls on each memory-clock rising edge, starting with the first rising edge at or after the access tick. A write produces none.
- R9: Done pulses for one tick, one tick after chip-select deasserts. At that point busy has cleared and the address strobe is low.
- R10: A start that arrives while busy is high has no effect. The running access keeps its timing, and no second access follows.
- R11: After reset, chip-select is high, and the memory clock, address strobe, capture, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | functional clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begin an access (one tick) |
| write_i | input | 1 | 1 = write, 0 = read |
| div_sel_i | input | 2 | memory-clock divider code |
| gran_i | input | 1 | doubles all timing fields |
| extra_dly_i | input | 1 | half-tick chip-select assertion delay |
| clk_act_i | input | TW | clock-start tick |
| cs_on_i | input | TW | chip-select assert tick |
| access_i | input | TW | first data-capture tick |
| rd_off_i | input | TW | end tick for reads |
| wr_off_i | input | TW | end tick for writes |
| burst_len_i | input | BLW | read capture count |
| mem_clk_o | output | 1 | memory clock |
| cs_n_o | output | 1 | chip-select, active low |
| addr_vld_o | output | 1 | address/byte-enable valid |
| cap_o | output | 1 | read-data capture strobe |
| busy_o | output | 1 | access in progress |
| done_o | output | 1 | access finished pulse |

## Verification
The assertions assume the following about the fields present at each start:
- The clock-start tick lies before the access tick.
- The adjusted chip-select assert point lies before the end tick.
- The last capture rising edge fits inside the window.
- The divider code is 0, 1 or 2.

The bench picks every field set with margin on all three conditions. This includes the granularity-doubled cases and a case where the assert tick precedes the clock-start tick. Inputs change only at falling edges. The only starts during an access are the ones that test R10.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  typedef enum logic [1:0] {
    DIV_BY1 = 2'd0,
    DIV_BY2 = 2'd1,
    DIV_BY3 = 2'd2
  } div_sel_e;

  function automatic logic [1:0] div_ratio(input logic [1:0] sel);
    case (div_sel_e'(sel))
      DIV_BY2: return 2'd2;
      DIV_BY3: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/ctg_clk_div.sv
module ctg_clk_div (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ratio_i,
  input  logic       run_i,
  output logic       rise_o,
  output logic       mem_clk_o
);
  logic [1:0] ph_q;
  logic       pos_hi_q, neg_hi_q, en_neg_q;

  assign rise_o = run_i && (ph_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= 2'd0;
      pos_hi_q <= 1'b0;
    end else begin
      pos_hi_q <= rise_o;
      if (!run_i || ph_q == ratio_i - 2'd1) ph_q <= 2'd0;
      else                                  ph_q <= ph_q + 2'd1;
    end
  end

  // half-tick retiming: gating enable for /1, phase extension for /3
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_neg_q <= 1'b0;
      neg_hi_q <= 1'b0;
    end else begin
      en_neg_q <= run_i;
      neg_hi_q <= pos_hi_q;
    end
  end

  always_comb begin
    case (ratio_i)
      2'd3:    mem_clk_o = pos_hi_q | neg_hi_q;
      2'd2:    mem_clk_o = pos_hi_q;
      default: mem_clk_o = clk_i & en_neg_q;
    endcase
  end
endmodule

// File: rtl/ctg_cs_align.sv
module ctg_cs_align #(
  parameter int unsigned TW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      ratio_i,
  input  logic            extra_i,
  input  logic            busy_i,
  input  logic [TW+1:0]   cnt_i,
  input  logic [TW:0]     ca_i,
  input  logic [TW:0]     cson_i,
  input  logic [TW:0]     off_i,
  output logic            cs_n_o
);
  localparam int unsigned SW = TW + 1;
  localparam int unsigned CW = SW + 1;
  localparam int unsigned XW = CW + 2;

  logic [XW-1:0] span;
  logic [1:0]    slip;
  logic [CW-1:0] at_tick;
  logic          active;
  logic          cs_pos_q, cs_neg_q;

  // bias by 3*2^SW keeps the difference positive without changing it mod 3
  assign span = XW'(cson_i) + (XW'(3) << SW) - XW'(ca_i);

  always_comb begin
    case (ratio_i)
      2'd2:    slip = {1'b0, cson_i[0] ^ ca_i[0]};
      2'd3:    slip = 2'(span % XW'(3));
      default: slip = 2'd0;
    endcase
  end

  assign at_tick = CW'(cson_i) + CW'(slip);
  assign active  = busy_i && (cnt_i >= at_tick) && (cnt_i < CW'(off_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_pos_q <= 1'b1;
    else         cs_pos_q <= ~active;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_neg_q <= 1'b1;
    else         cs_neg_q <= cs_pos_q;
  end

  // delay only the asserting edge
  assign cs_n_o = extra_i ? (cs_pos_q | cs_neg_q) : cs_pos_q;
endmodule

// File: rtl/ctg_cap_gen.sv
module ctg_cap_gen #(
  parameter int unsigned BLW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [BLW-1:0] blen_i,
  input  logic           rise_i,
  input  logic           past_acc_i,
  output logic           cap_o
);
  logic [BLW-1:0] rem_q;
  logic           fire;
  logic           cap_q;

  assign fire  = rise_i && past_acc_i && (rem_q != '0);
  assign cap_o = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= fire;
      if (load_i)    rem_q <= blen_i;
      else if (fire) rem_q <= rem_q - BLW'(1);
    end
  end
endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
  import ctg_pkg::*;
#(
  parameter int unsigned TW  = 6,
  parameter int unsigned BLW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           write_i,
  input  logic [1:0]     div_sel_i,
  input  logic           gran_i,
  input  logic           extra_dly_i,
  input  logic [TW-1:0]  clk_act_i,
  input  logic [TW-1:0]  cs_on_i,
  input  logic [TW-1:0]  access_i,
  input  logic [TW-1:0]  rd_off_i,
  input  logic [TW-1:0]  wr_off_i,
  input  logic [BLW-1:0] burst_len_i,
  output logic           mem_clk_o,
  output logic           cs_n_o,
  output logic           addr_vld_o,
  output logic           cap_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int unsigned SW = TW + 1;
  localparam int unsigned CW = SW + 1;

  function automatic logic [SW-1:0] scale(input logic [TW-1:0] v, input logic g);
    return g ? {v, 1'b0} : {1'b0, v};
  endfunction

  logic          busy_q, done_q, addr_q, ext_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    ratio_q;
  logic [SW-1:0] ca_q, cson_q, acc_q, off_q;
  logic [CW-1:0] end_cnt;
  logic          start_ok, in_win, clk_run, past_acc, rise;

  assign start_ok = start_i & ~busy_q;
  assign end_cnt  = CW'(off_q) + CW'(1);
  assign in_win   = busy_q && (cnt_q < CW'(off_q));
  assign clk_run  = in_win && (cnt_q >= CW'(ca_q));
  assign past_acc = cnt_q >= CW'(acc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= 1'b0;
      ext_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= 2'd1;
      ca_q    <= '0;
      cson_q  <= '0;
      acc_q   <= '0;
      off_q   <= '0;
    end else begin
      done_q <= busy_q && (cnt_q == end_cnt);
      addr_q <= in_win;
      if (start_ok) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        ext_q   <= extra_dly_i;
        ratio_q <= div_ratio(div_sel_i);
        ca_q    <= scale(clk_act_i, gran_i);
        cson_q  <= scale(cs_on_i, gran_i);
        acc_q   <= scale(access_i, gran_i);
        off_q   <= scale(write_i ? wr_off_i : rd_off_i, gran_i);
      end else if (busy_q) begin
        if (cnt_q == end_cnt) busy_q <= 1'b0;
        else                  cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  ctg_clk_div u_clk_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_i   (ratio_q),
    .run_i     (clk_run),
    .rise_o    (rise),
    .mem_clk_o (mem_clk_o)
  );

  ctg_cs_align #(.TW(TW)) u_cs_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio_q),
    .extra_i (ext_q),
    .busy_i  (busy_q),
    .cnt_i   (cnt_q),
    .ca_i    (ca_q),
    .cson_i  (cson_q),
    .off_i   (off_q),
    .cs_n_o  (cs_n_o)
  );

  ctg_cap_gen #(.BLW(BLW)) u_cap_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_ok),
    .blen_i     (write_i ? '0 : burst_len_i),
    .rise_i     (rise),
    .past_acc_i (past_acc),
    .cap_o      (cap_o)
  );

  assign addr_vld_o = addr_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
endmodule

// File: rtl/cs_timing_gen_chk.sv
module cs_timing_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_n_o,
  input logic addr_vld_o,
  input logic cap_o,
  input logic busy_o,
  input logic done_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !addr_vld_o && !busy_o));

  // R2
  cs_inside_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> addr_vld_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_n_o && !addr_vld_o && !cap_o));

  // R10
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R8
  cap_in_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> busy_o);
endmodule

bind cs_timing_gen cs_timing_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cs_n_o     (cs_n_o),
  .addr_vld_o (addr_vld_o),
  .cap_o      (cap_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/cs_timing_gen_tb.sv
`timescale 1ns/1ps
module cs_timing_gen_tb;
  localparam int TW  = 6;
  localparam int BLW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, write_i = 1'b0, gran_i = 1'b0, extra_dly_i = 1'b0;
  logic [1:0] div_sel_i = 2'd0;
  logic [TW-1:0] clk_act_i = '0, cs_on_i = '0, access_i = '0, rd_off_i = '0, wr_off_i = '0;
  logic [BLW-1:0] burst_len_i = '0;
  logic mem_clk_o, cs_n_o, addr_vld_o, cap_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  cs_timing_gen #(.TW(TW), .BLW(BLW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .div_sel_i(div_sel_i), .gran_i(gran_i), .extra_dly_i(extra_dly_i),
    .clk_act_i(clk_act_i), .cs_on_i(cs_on_i), .access_i(access_i),
    .rd_off_i(rd_off_i), .wr_off_i(wr_off_i), .burst_len_i(burst_len_i),
    .mem_clk_o(mem_clk_o), .cs_n_o(cs_n_o), .addr_vld_o(addr_vld_o),
    .cap_o(cap_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    int ca_h, fall_h, rise_h, n_rise, n_cap, cap_h, ratio;
    string cs_tag, end_tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int checks = 0, errs = 0, done_cnt = 0;
  int h = 0, h0 = 0, fr_h = 0, last_r = 0, n_r = 0, hi = 0, bad_per = 0, bad_hi = 0;
  int cs_f = 0, cs_r = 0, adv_f = 0, n_c = 0, cap_h = 0, bad_cap = 0;
  bit trk = 0, p_mc = 0, p_cs = 1, p_adv = 0, p_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: half-tick samples, pops the scoreboard on each done
  task automatic smp(input bit pos);
    bit mc, cs, adv, cp, dn, mrise;
    h++;
    mc = mem_clk_o; cs = cs_n_o; adv = addr_vld_o; cp = cap_o; dn = done_o;
    mrise = mc && !p_mc;
    if (adv && !p_adv) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected access", 1, 0);
      else begin
        cur = exp_q.pop_front(); trk = 1; h0 = h;
        n_r = 0; hi = 0; bad_per = 0; bad_hi = 0; n_c = 0; bad_cap = 0;
        fr_h = -1; cs_f = -1; cs_r = -1; adv_f = -1; cap_h = -1;
      end
    end
    if (trk) begin
      if (mrise) begin
        if (n_r == 0) fr_h = h - h0;
        else if (h - last_r != 2 * cur.ratio) bad_per++;
        last_r = h; n_r++; hi = 0;
      end
      if (mc) hi++;
      if (!mc && p_mc && hi != cur.ratio) bad_hi++;
      if (!cs && p_cs) cs_f = h - h0;
      if (cs && !p_cs) cs_r = h - h0;
      if (!adv && p_adv) adv_f = h - h0;
      if (pos && cp) begin
        n_c++;
        if (n_c == 1) cap_h = h - h0;
        if (!mrise) bad_cap++;
      end
      if (pos && dn && !p_done) begin
        chk(fr_h == cur.ca_h, "R2 first clock edge", fr_h, cur.ca_h);
        chk(adv_f == cur.rise_h, "R2 addr strobe end", adv_f, cur.rise_h);
        chk(cs_f - fr_h == cur.fall_h - cur.ca_h, cur.cs_tag, cs_f - fr_h, cur.fall_h - cur.ca_h);
        chk(cs_r == cur.rise_h, cur.end_tag, cs_r, cur.rise_h);
        chk(n_r == cur.n_rise, "R1 rise count", n_r, cur.n_rise);
        chk(bad_per == 0, "R1 period", bad_per, 0);
        chk(bad_hi == 0, "R1 high phase", bad_hi, 0);
        chk(n_c == cur.n_cap, "R8 capture count", n_c, cur.n_cap);
        if (cur.n_cap > 0) chk(cap_h == cur.cap_h, "R8 first capture", cap_h, cur.cap_h);
        chk(bad_cap == 0, "R8 capture on rise", bad_cap, 0);
        chk(h - h0 == cur.rise_h + 2, "R9 done timing", h - h0, cur.rise_h + 2);
        trk = 0; done_cnt++;
      end
    end
    p_mc = mc; p_cs = cs; p_adv = adv; p_done = dn;
  endtask

  initial forever begin
    @(posedge clk); #1 smp(1'b1);
    @(negedge clk); #1 smp(1'b0);
  end

  // driver: computes expectations from the requirements, pushes, starts
  task automatic run_access(input int div, input int wr, input int gran, input int ext,
                            input int ca, input int cson, input int acc,
                            input int rdoff, input int wroff, input int blen,
                            input bit intrude);
    exp_t e;
    int s, n, cas, csos, accs, offs, slip, d, g, d0, k;
    s = gran + 1; n = div + 1;
    cas = ca * s; csos = cson * s; accs = acc * s; offs = (wr ? wroff : rdoff) * s;
    d = csos - cas;
    if (n == 2) slip = (d % 2 != 0) ? 1 : 0;
    else if (n == 3) slip = ((d % 3) + 3) % 3;
    else slip = 0;
    g = cas + n * ((accs - cas + n - 1) / n);
    e.ratio  = n;
    e.ca_h   = 2 * cas;
    e.fall_h = 2 * (csos + slip) + ext;
    e.rise_h = 2 * offs;
    e.n_rise = (offs - cas + n - 1) / n;
    e.n_cap  = wr ? 0 : blen;
    e.cap_h  = 2 * g;
    e.cs_tag = ext ? "R5 cs assert half tick" : (n == 3 ? "R4 cs assert mod3" : "R3 cs assert parity");
    e.end_tag = gran ? "R7 doubled end tick" : "R6 cs deassert";
    exp_q.push_back(e);
    @(negedge clk);
    div_sel_i = 2'(div); write_i = wr[0]; gran_i = gran[0]; extra_dly_i = ext[0];
    clk_act_i = TW'(ca); cs_on_i = TW'(cson); access_i = TW'(acc);
    rd_off_i = TW'(rdoff); wr_off_i = TW'(wroff); burst_len_i = BLW'(blen);
    d0 = done_cnt;
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      // R10: competing start with other fields during the access
      start_i = 1'b1; write_i = ~write_i; div_sel_i = 2'd2; clk_act_i = 1; rd_off_i = 40; wr_off_i = 40;
      @(negedge clk); start_i = 1'b0;
    end
    k = 0;
    while (done_cnt == d0 && k < 3000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R9 watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(cs_n_o == 1'b1, "R11 cs_n", cs_n_o, 1);
    chk(mem_clk_o == 1'b0 && addr_vld_o == 1'b0, "R11 clk/addr", {mem_clk_o, addr_vld_o}, 0);
    chk(cap_o == 1'b0 && busy_o == 1'b0 && done_o == 1'b0, "R11 cap/busy/done",
        {cap_o, busy_o, done_o}, 0);

    // R1 R3 R4 R5 R6 R8: every divider with both parities of each tick
    for (int dv = 0; dv < 3; dv++)
      for (int pa = 0; pa < 2; pa++)
        for (int pb = 0; pb < 2; pb++)
          run_access(dv, (pa + pb) % 2, 0, pa, 2 + pa, 4 + pb, 8, 18, 20, 3, 1'b0);

    // R7 doubled fields, R5 with doubling
    run_access(1, 0, 1, 0, 3, 4, 6, 10, 12, 3, 1'b0);
    run_access(2, 0, 1, 1, 3, 4, 6, 10, 12, 3, 1'b0);
    run_access(2, 1, 1, 0, 3, 4, 6, 14, 10, 2, 1'b0);
    // R4 assert tick ahead of clock start
    run_access(2, 0, 0, 0, 5, 3, 7, 16, 16, 2, 1'b0);
    // R3 divider 0, long burst; R8 zero-length read
    run_access(0, 0, 0, 1, 5, 2, 7, 12, 12, 4, 1'b0);
    run_access(1, 0, 0, 0, 2, 3, 4, 12, 12, 0, 1'b0);
    // R10 start during an access
    run_access(1, 0, 0, 0, 2, 4, 6, 16, 16, 2, 1'b1);
    repeat (60) @(negedge clk);
    chk(busy_o == 1'b0, "R10 no second access", busy_o, 0);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule